// File: doc/BRIEF.md
# Operand-Size-Aware Call/Return Stack Unit

This unit performs control transfers (jump, call and return). It saves and restores the instruction pointer on a small byte-addressed stack that it holds inside. Each command carries its own operand-size attribute, 16 or 32 bits. That attribute sets how wide the target offset is and how many bytes each push or pop moves. A separate stack-size bit sets the width of the stack pointer arithmetic: 16-bit wrap or full 32-bit.

On a transfer that crosses privilege levels, the unit also saves the caller's stack pointer on a call and restores it on a return. A return always pops according to its own operand size. When that size differs from the size of the call that built the frame, the unit pops exactly what the return asks for. The instruction pointer and stack pointer are then left wrong, and nothing repairs them.

Commands enter over a valid/ready handshake. `cmd_ready` is high only while the unit is idle. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. While a command runs, `cmd_ready` stays low, and the source must hold its command until `cmd_ready` returns. The stack traffic and the result pins are plain outputs with no back-pressure.

Top module: `ctl_xfer_stack`

## Requirements
- R1: After reset the instruction pointer is 0 and the stack pointer equals the `TOS` parameter (default 0x100). `cmd_ready` is 1, `done` is 0 and every stack byte reads 0.
- R2: An accepted command holds `cmd_ready` low for exactly one cycle per stack byte it touches. `done` pulses for one cycle after the final byte, or in the cycle after acceptance when no byte is touched. `cmd_ready` is high during that pulse.
- R3: Opcode 0 (jump) loads the instruction pointer with the target. With a 16-bit operand size, only target bits 15:0 are kept and the upper half becomes zero. Opcode 3 completes in one cycle and changes nothing.
- R4: Opcode 1 (call) with a 16-bit operand size pushes bits 15:0 of the current instruction pointer as 2 bytes, then loads the masked target.
- R5: A call with a 32-bit operand size pushes all 32 bits of the instruction pointer as 4 bytes.
- R6: An inter-privilege call first pushes the stack pointer value held at acceptance (2 or 4 bytes, by operand size). It then pushes the instruction pointer.
- R7: Opcode 2 (return) pops 2 or 4 bytes by its own operand size and zero-extends the value into the instruction pointer. An inter-privilege return then pops a second value of the same width and loads it, zero-extended, into the stack pointer.
- R8: A return whose operand size differs from the call that built the frame still pops its own width, with no correction. For example, after a 32-bit call from 0x12345678, a 16-bit return gives instruction pointer 0x5678 and leaves the stack pointer 2 below its value before the call.
- R9: A push decrements the stack pointer by the item size before storing, and a pop increments it after reading. With stack-size bit 0, this arithmetic wraps modulo 2^16 and bits 31:16 are unchanged. With stack-size bit 1, it uses all 32 bits.
- R10: A jump or call with a 32-bit operand size, a 16-bit destination flag and a target above 0xFFFF asserts `range_err` together with `done`. The instruction pointer, stack pointer and stack stay unchanged, and no stack traffic occurs.
- R11: Each item is stored little-endian: byte k of the item goes to the stack-pointer value after decrement plus k. Every stack byte touched shows up for one cycle with `mem_we` (write) or `mem_re` (read), plus the address `mem_addr` (the low `AW` bits of that pointer value) and the data `mem_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command may be taken |
| cmd_op | input | 2 | 0 jump, 1 call, 2 return, 3 no effect |
| cmd_osz32 | input | 1 | Operand size: 1 = 32-bit, 0 = 16-bit |
| cmd_inter | input | 1 | Inter-privilege transfer (save/restore stack pointer) |
| cmd_dst16 | input | 1 | Destination segment is 16-bit |
| cmd_stk32 | input | 1 | Stack-size bit: 1 = 32-bit pointer, 0 = 16-bit |
| cmd_target | input | 32 | Target offset |
| ip | output | 32 | Instruction pointer |
| sp | output | 32 | Stack pointer |
| done | output | 1 | Command complete pulse |
| range_err | output | 1 | Target out of range for 16-bit destination, with done |
| mem_we | output | 1 | Stack byte written this cycle |
| mem_re | output | 1 | Stack byte read this cycle |
| mem_addr | output | AW | Stack byte address |
| mem_byte | output | 8 | Byte written or read |

## Verification
The assertions assume that `cmd_valid` and the command fields stay stable and known from the moment they are offered until the handshake. They also assume reset is held long enough for the stack array to clear. The bench drives every command on a falling edge, only after it has seen `cmd_ready` high. It drops `cmd_valid` one cycle later and never offers a new command before the previous `done`. Stack-pointer wrap is reached legally: an inter-privilege return loads a small stack pointer from a frame the bench built earlier.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    OP_JMP  = 2'd0,
    OP_CALL = 2'd1,
    OP_RET  = 2'd2,
    OP_NONE = 2'd3
  } xfer_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } xfer_st_e;
endpackage

// File: rtl/xfer_ptr_step.sv
module xfer_ptr_step (
  input  logic [31:0] base,
  input  logic [2:0]  amt,
  input  logic        down,
  input  logic        wide,
  output logic [31:0] result
);
  logic [31:0] full;
  always_comb begin
    full   = down ? (base - {29'd0, amt}) : (base + {29'd0, amt});
    result = wide ? full : {base[31:16], full[15:0]};
  end
endmodule

// File: rtl/xfer_stack_mem.sv
module xfer_stack_mem #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/ctl_xfer_stack.sv
module ctl_xfer_stack
  import xfer_pkg::*;
#(
  parameter int          AW  = 8,
  parameter logic [31:0] TOS = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_osz32,
  input  logic          cmd_inter,
  input  logic          cmd_dst16,
  input  logic          cmd_stk32,
  input  logic [31:0]   cmd_target,
  output logic [31:0]   ip,
  output logic [31:0]   sp,
  output logic          done,
  output logic          range_err,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_byte
);
  xfer_st_e    st_q;
  xfer_op_e    op_q;
  logic        osz_q, inter_q, stk_q, item_q;
  logic [1:0]  byte_q;
  logic [31:0] tgt_q, acc_q, snap_q, ip_q, sp_q;
  logic        done_q, err_q;

  // command decode at the handshake
  logic        take, bad_cmd;
  logic [31:0] tmask;
  assign cmd_ready = (st_q == ST_IDLE);
  assign take      = cmd_valid && cmd_ready;
  assign tmask     = cmd_osz32 ? cmd_target : {16'h0000, cmd_target[15:0]};
  assign bad_cmd   = cmd_osz32 && cmd_dst16 && (cmd_target[31:16] != 16'h0000)
                     && (cmd_op != OP_RET);

  // per-byte sequencing
  logic        busy, is_push, last_byte, last_item;
  logic [2:0]  nbytes, addr_amt;
  logic [31:0] cur_val, addr_full, sp_next, acc_full, popped;
  logic [7:0]  rd_byte, wr_byte;

  assign busy      = (st_q == ST_BUSY);
  assign is_push   = (op_q == OP_CALL);
  assign nbytes    = osz_q ? 3'd4 : 3'd2;
  assign last_byte = ({1'b0, byte_q} == (nbytes - 3'd1));
  assign last_item = inter_q ? item_q : 1'b1;
  assign cur_val   = (inter_q && !item_q) ? snap_q : ip_q;
  assign addr_amt  = is_push ? (nbytes - {1'b0, byte_q}) : {1'b0, byte_q};
  assign wr_byte   = cur_val[{byte_q, 3'b000} +: 8];
  assign acc_full  = acc_q | ({24'd0, rd_byte} << {byte_q, 3'b000});
  assign popped    = osz_q ? acc_full : {16'h0000, acc_full[15:0]};

  xfer_ptr_step u_addr (
    .base(sp_q), .amt(addr_amt), .down(is_push), .wide(stk_q), .result(addr_full)
  );

  xfer_ptr_step u_next (
    .base(sp_q), .amt(nbytes), .down(is_push), .wide(stk_q), .result(sp_next)
  );

  xfer_stack_mem #(.AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(busy && is_push),
    .addr(addr_full[AW-1:0]), .wdata(wr_byte), .rdata(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NONE;
      osz_q   <= 1'b0;
      inter_q <= 1'b0;
      stk_q   <= 1'b0;
      item_q  <= 1'b0;
      byte_q  <= 2'd0;
      tgt_q   <= 32'd0;
      acc_q   <= 32'd0;
      snap_q  <= 32'd0;
      ip_q    <= 32'd0;
      sp_q    <= TOS;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (cmd_valid) begin
          op_q    <= xfer_op_e'(cmd_op);
          osz_q   <= cmd_osz32;
          inter_q <= cmd_inter;
          stk_q   <= cmd_stk32;
          tgt_q   <= tmask;
          snap_q  <= sp_q;
          item_q  <= 1'b0;
          byte_q  <= 2'd0;
          acc_q   <= 32'd0;
          if (bad_cmd) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else if (cmd_op == OP_CALL || cmd_op == OP_RET) begin
            st_q <= ST_BUSY;
          end else begin
            if (cmd_op == OP_JMP) ip_q <= tmask;
            done_q <= 1'b1;
          end
        end
      end else begin
        acc_q  <= acc_full;
        byte_q <= byte_q + 2'd1;
        if (last_byte) begin
          byte_q <= 2'd0;
          acc_q  <= 32'd0;
          sp_q   <= sp_next;
          if (!is_push) begin
            if (inter_q && item_q) sp_q <= popped;
            else                   ip_q <= popped;
          end
          if (last_item) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            if (is_push) ip_q <= tgt_q;
          end else begin
            item_q <= 1'b1;
          end
        end
      end
    end
  end

  assign ip        = ip_q;
  assign sp        = sp_q;
  assign done      = done_q;
  assign range_err = err_q;
  assign mem_we    = busy && is_push;
  assign mem_re    = busy && !is_push;
  assign mem_addr  = addr_full[AW-1:0];
  assign mem_byte  = is_push ? wr_byte : rd_byte;

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bad_cmd && (cmd_op == OP_CALL || cmd_op == OP_RET)) |=> !cmd_ready);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  // R3
  jmp16_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == OP_JMP && !cmd_osz32) |=> (ip[31:16] == 16'h0000));

  // R10
  range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> ($stable(ip) && $stable(sp)));

  // R9
  sp16_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !stk_q) |=> $stable(sp[31:16]));
endmodule

// File: tb/sim_ctl_xfer_stack.sv
module sim_ctl_xfer_stack;
  localparam int          CLK_P = 10;
  localparam int          AW    = 8;
  localparam logic [31:0] TOS   = 32'h0000_0100;
  localparam int          WD    = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic          cmd_osz32 = 1'b0, cmd_inter = 1'b0, cmd_dst16 = 1'b0, cmd_stk32 = 1'b0;
  logic [31:0]   cmd_target = 32'd0;
  logic [31:0]   ip, sp;
  logic          done, range_err, mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_byte;

  always #(CLK_P/2) clk = ~clk;

  ctl_xfer_stack #(.AW(AW), .TOS(TOS)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_osz32(cmd_osz32), .cmd_inter(cmd_inter),
    .cmd_dst16(cmd_dst16), .cmd_stk32(cmd_stk32), .cmd_target(cmd_target),
    .ip(ip), .sp(sp), .done(done), .range_err(range_err),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_byte(mem_byte)
  );

  typedef struct {
    logic [31:0] ip;
    logic [31:0] sp;
    logic        err;
    int          nb;
    string       req;
  } res_t;

  typedef struct {
    logic       we;
    logic [7:0] addr;
    logic [7:0] data;
    string      req;
  } tr_t;

  res_t res_q[$];
  tr_t  tr_q[$];
  int   n_tests = 0, n_fail = 0, busy_cnt = 0;
  bit   finished = 0;

  logic [31:0] m_ip, m_sp;
  logic [7:0]  m_mem [256];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] b, input int n,
                                       input bit down, input bit w32);
    logic [31:0] f;
    f = down ? b - n : b + n;
    return w32 ? f : {b[31:16], f[15:0]};
  endfunction

  task automatic m_push(input logic [31:0] v, input bit o32, input bit s32, input string req);
    int n;
    logic [7:0] a;
    n = o32 ? 4 : 2;
    for (int k = 0; k < n; k++) begin
      a = step(m_sp, n - k, 1'b1, s32)[7:0];
      m_mem[a] = v[8*k +: 8];
      tr_q.push_back('{1'b1, a, v[8*k +: 8], req});
    end
    m_sp = step(m_sp, n, 1'b1, s32);
  endtask

  task automatic m_pop(output logic [31:0] v, input bit o32, input bit s32, input string req);
    int n;
    logic [7:0] a;
    n = o32 ? 4 : 2;
    v = 32'd0;
    for (int k = 0; k < n; k++) begin
      a = step(m_sp, k, 1'b0, s32)[7:0];
      v[8*k +: 8] = m_mem[a];
      tr_q.push_back('{1'b0, a, m_mem[a], req});
    end
    m_sp = step(m_sp, n, 1'b0, s32);
  endtask

  task automatic send(input logic [1:0] op, input bit o32, input bit inter, input bit d16,
                      input bit s32, input logic [31:0] tgt, input string req);
    logic [31:0] tm, v, snap;
    bit bad;
    int nb;
    tm  = o32 ? tgt : {16'h0000, tgt[15:0]};
    bad = o32 && d16 && (tgt[31:16] != 16'h0000) && (op != 2'd2);
    nb  = 0;
    if (!bad) begin
      if (op == 2'd0) m_ip = tm;
      else if (op == 2'd1) begin
        snap = m_sp;
        if (inter) m_push(snap, o32, s32, req);
        m_push(m_ip, o32, s32, req);
        m_ip = tm;
        nb = (inter ? 2 : 1) * (o32 ? 4 : 2);
      end else if (op == 2'd2) begin
        m_pop(v, o32, s32, req);
        m_ip = v;
        if (inter) begin
          m_pop(v, o32, s32, req);
          m_sp = v;
        end
        nb = (inter ? 2 : 1) * (o32 ? 4 : 2);
      end
    end
    res_q.push_back('{m_ip, m_sp, bad, nb, req});
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_osz32 = o32; cmd_inter = inter; cmd_dst16 = d16;
    cmd_stk32 = s32; cmd_target = tgt; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (res_q.size() != 0) @(negedge clk);
  endtask

  // monitor: compares traffic and results as the design produces them
  res_t r;
  tr_t  t;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cmd_ready) busy_cnt++;
      if (mem_we || mem_re) begin
        if (tr_q.size() == 0) chk("R11", "unexpected traffic", {24'd0, mem_addr}, 32'hFFFF_FFFF);
        else begin
          t = tr_q.pop_front();
          chk(t.req, "R11 traffic we", {31'd0, mem_we}, {31'd0, t.we});
          chk(t.req, "R11 traffic addr", {24'd0, mem_addr}, {24'd0, t.addr});
          chk(t.req, "R11 traffic byte", {24'd0, mem_byte}, {24'd0, t.data});
        end
      end
      if (done) begin
        if (res_q.size() == 0) chk("R2", "unexpected done", 32'd1, 32'd0);
        else begin
          r = res_q.pop_front();
          chk(r.req, "ip", ip, r.ip);
          chk(r.req, "sp", sp, r.sp);
          chk(r.req, "range_err", {31'd0, range_err}, {31'd0, r.err});
          chk("R2", "busy cycles", busy_cnt, r.nb);
          chk("R2", "ready at done", {31'd0, cmd_ready}, 32'd1);
        end
        busy_cnt = 0;
      end
    end
  end

  initial begin
    m_ip = 32'd0;
    m_sp = TOS;
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    repeat (300) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset ip", ip, 32'd0);
    chk("R1", "reset sp", sp, TOS);
    chk("R1", "reset ready", {31'd0, cmd_ready}, 32'd1);
    chk("R1", "reset done", {31'd0, done}, 32'd0);

    send(2'd0, 1, 0, 0, 0, 32'h1234_5678, "R3 jmp32");
    send(2'd0, 0, 0, 0, 0, 32'hABCD_1234, "R3 jmp16");
    send(2'd3, 1, 0, 0, 0, 32'h5555_5555, "R3 op3");
    send(2'd0, 1, 0, 1, 0, 32'h0001_2345, "R10 jmp range");
    send(2'd1, 1, 0, 0, 1, 32'h0000_4000, "R5 call32");
    send(2'd2, 1, 0, 0, 1, 32'd0,         "R7 ret32");
    send(2'd1, 0, 1, 0, 0, 32'h0002_2222, "R6 R4 inter call16");
    send(2'd2, 0, 1, 0, 0, 32'd0,         "R7 inter ret16");
    send(2'd1, 1, 1, 0, 1, 32'h0000_3000, "R6 inter call32");
    send(2'd2, 1, 1, 0, 1, 32'd0,         "R7 inter ret32");
    send(2'd0, 1, 0, 0, 0, 32'h1234_5678, "R8 setup");
    send(2'd1, 1, 0, 0, 0, 32'h0000_0010, "R8 call32");
    send(2'd2, 0, 0, 0, 0, 32'd0,         "R8 ret16 mismatch");
    // stack-pointer wrap with a 16-bit stack
    send(2'd0, 0, 0, 0, 0, 32'h0000_0001, "R9 setup a");
    send(2'd1, 0, 0, 0, 0, 32'h0000_0777, "R9 setup b");
    send(2'd1, 0, 0, 0, 0, 32'h0000_0888, "R9 setup c");
    send(2'd2, 0, 1, 0, 0, 32'd0,         "R9 load sp");
    send(2'd1, 0, 0, 0, 0, 32'h0000_0040, "R9 wrap16");
    // same with a 32-bit stack
    send(2'd0, 0, 0, 0, 1, 32'h0000_0001, "R9 setup d");
    send(2'd1, 0, 0, 0, 1, 32'h0000_0777, "R9 setup e");
    send(2'd1, 0, 0, 0, 1, 32'h0000_0888, "R9 setup f");
    send(2'd2, 0, 1, 0, 1, 32'd0,         "R9 load sp32");
    send(2'd1, 0, 0, 0, 1, 32'h0000_0050, "R9 wrap32");
    send(2'd1, 1, 0, 1, 1, 32'h0001_0000, "R10 call range");
    send(2'd1, 1, 0, 1, 1, 32'h0000_FFFF, "R10 call edge ok");
    repeat (5) @(negedge clk);
    chk("R11", "traffic drained", tr_q.size(), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule